// File: doc/BRIEF.md
# Root Port Reset and Link Sequencer

This block brings up two root ports of a serial-link host controller from a cold reset. Once the block leaves reset, it runs one fixed, timed sequence with no further commands. It holds the attached devices in reset and turns on the second port's clock. It then cycles the controller resets of both ports and of the bridge, releases the devices, and waits for the links to settle. After that it samples the link-up status a bounded number of times. When the sequence ends, every expected port that has no link has its PHY switched off, the final link status is presented, and a sticky done flag is raised. A host-enable flag goes high only if at least one port came up. Register programming that follows bring-up is left to other logic.

Every wait is a parameter counted in clock ticks. The parameter `PORT1_EN` states whether the second port is fitted. The state machine moves through these named states: `ST_DEV_HOLD` → `ST_CLK_ON` → `ST_CTRL_REL_A` → `ST_CTRL_HOLD` → `ST_CTRL_REL_B` → `ST_SETTLE` → `ST_POLL`. From `ST_POLL` it goes to `ST_FINISH` when all required links are up or the poll budget is spent. Otherwise it goes to `ST_GAP`, and from there back to `ST_POLL`. `ST_FINISH` holds until reset. Each timed state lasts exactly its parameter in cycles, and `ST_POLL` lasts one cycle.

Top module: `rp_bringup_seq`

## Requirements
- R1: While `rst_n` is low the outputs are: `dev_rst_n_o`=00, `port1_clk_en_o`=0, `ctrl_rst_o`=111, `phy_off_o`=00, `link_up_o`=00, `host_en_o`=0, `done_o`=0.
- R2: After reset is released, the device resets stay low for `T_DEV_LOW` cycles. Then `port1_clk_en_o` rises and stays high. The next `T_CLK_ON` cycles pass with the devices still in reset and all controller resets still asserted.
- R3: The three controller reset lines (bit 0 port 0, bit 1 port 1, bit 2 bridge) always move together. They are released for `T_REL_A` cycles, asserted for `T_CTRL_HOLD` cycles, and then released for `T_REL_B` cycles, with the device resets still low throughout.
- R4: Both device resets then go high, and no link sample is taken during the next `T_SETTLE` cycles.
- R5: The status is sampled at most `POLL_MAX` times. Successive samples are `T_GAP+1` cycles apart.
- R6: Sampling stops at the first sample in which every required port shows link up. `done_o` rises in the cycle after that sample.
- R7: Port 0's link is read from `link_sts_i[1]` and port 1's from `link_sts_i[2]`. `link_sts_i[0]` has no effect.
- R8: When done, `phy_off_o[i]` is high exactly for each required port `i` whose last sample showed no link. Before done, `phy_off_o` is 00.
- R9: When done, `link_up_o` gives the last sampled status of the required ports, and `host_en_o` is high only if `link_up_o` is nonzero. With `PORT1_EN`=0, bit 1 of `link_up_o` and of `phy_off_o` stays 0, and only port 0 is needed for the early stop.
- R10: Once high, `done_o` stays high until reset, and `link_up_o`, `phy_off_o` and `host_en_o` no longer change whatever the input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; sequence starts on release |
| link_sts_i | input | 3 | Link-up status; bit 1 port 0, bit 2 port 1, bit 0 ignored |
| dev_rst_n_o | output | 2 | Active-low reset to the device on each port |
| port1_clk_en_o | output | 1 | Clock enable for port 1 |
| ctrl_rst_o | output | 3 | Active-high controller resets: port 0, port 1, bridge |
| phy_off_o | output | 2 | PHY disable per port, high for a port with no link |
| link_up_o | output | 2 | Final link status per port, valid with done |
| host_en_o | output | 1 | High at the end if any port has a link |
| done_o | output | 1 | Sticky end-of-sequence flag |

## Verification
The embedded assertions check, on every cycle, these invariants:
- the controller reset lines never separate;
- the port clock is on whenever the controllers are out of reset;
- the devices are released before any sample is taken;
- the poll count stays within bounds;
- done is sticky, and the final outputs freeze once done is high;
- a PHY is never switched off for a port whose link is reported up.

The exact durations of each phase, the cycle in which done rises for a given pattern of link arrivals, and the fact that bit 0 of the status input is ignored can only be shown by the bench's scenarios. The bench checks these by walking a table of link-arrival patterns on a two-port instance and a one-port instance side by side.

// File: rtl/rp_seq_pkg.sv
package rp_seq_pkg;

    typedef enum logic [3:0] {
        ST_DEV_HOLD   = 4'd0,
        ST_CLK_ON     = 4'd1,
        ST_CTRL_REL_A = 4'd2,
        ST_CTRL_HOLD  = 4'd3,
        ST_CTRL_REL_B = 4'd4,
        ST_SETTLE     = 4'd5,
        ST_POLL       = 4'd6,
        ST_GAP        = 4'd7,
        ST_FINISH     = 4'd8
    } seq_state_e;

    localparam int unsigned NUM_PORTS = 2;
    localparam int unsigned NUM_CTRL  = 3;

endpackage

// File: rtl/rp_phase_timer.sv
module rp_phase_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          clr,
    input  logic [CW-1:0] limit,
    output logic          hit
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit = (cnt_q == (limit - 1'b1));

    // the count never passes the limit of a running phase
    assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr && limit != '0) |-> (cnt_q < limit));

endmodule

// File: rtl/rp_link_poller.sv
module rp_link_poller #(
    parameter int unsigned PORT1_EN = 1,
    parameter int unsigned POLL_MAX = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample,
    input  logic [1:0] link_raw,
    output logic [1:0] link_q,
    output logic [1:0] phy_off_mask,
    output logic       all_up,
    output logic       last_poll
);

    localparam int unsigned PW = $clog2(POLL_MAX + 1);

    logic [1:0]    req_mask;
    logic [1:0]    link_masked;
    logic [PW-1:0] poll_cnt_q;

    generate
        if (PORT1_EN != 0) begin : g_two_ports
            assign req_mask = 2'b11;
        end else begin : g_one_port
            assign req_mask = 2'b01;
            assert_port1_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (link_q[1] == 1'b0) && (phy_off_mask[1] == 1'b0));
        end
    endgenerate

    assign link_masked  = link_raw & req_mask;
    assign all_up       = (link_masked == req_mask);
    assign last_poll    = (poll_cnt_q == PW'(POLL_MAX - 1));
    assign phy_off_mask = req_mask & ~link_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            link_q     <= 2'b00;
            poll_cnt_q <= '0;
        end else if (sample) begin
            link_q     <= link_masked;
            poll_cnt_q <= poll_cnt_q + 1'b1;
        end
    end

    assert_poll_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        poll_cnt_q <= PW'(POLL_MAX));

endmodule

// File: rtl/rp_bringup_seq.sv
module rp_bringup_seq
    import rp_seq_pkg::*;
#(
    parameter int unsigned T_DEV_LOW   = 100000,
    parameter int unsigned T_CLK_ON    = 100000,
    parameter int unsigned T_REL_A     = 100000,
    parameter int unsigned T_CTRL_HOLD = 10000000,
    parameter int unsigned T_REL_B     = 1000000,
    parameter int unsigned T_SETTLE    = 25000000,
    parameter int unsigned T_GAP       = 2000000,
    parameter int unsigned POLL_MAX    = 20,
    parameter int unsigned PORT1_EN    = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] link_sts_i,
    output logic [1:0] dev_rst_n_o,
    output logic       port1_clk_en_o,
    output logic [2:0] ctrl_rst_o,
    output logic [1:0] phy_off_o,
    output logic [1:0] link_up_o,
    output logic       host_en_o,
    output logic       done_o
);

    localparam int unsigned M1 = (T_DEV_LOW > T_CLK_ON) ? T_DEV_LOW : T_CLK_ON;
    localparam int unsigned M2 = (T_REL_A > T_CTRL_HOLD) ? T_REL_A : T_CTRL_HOLD;
    localparam int unsigned M3 = (T_REL_B > T_SETTLE) ? T_REL_B : T_SETTLE;
    localparam int unsigned M4 = (M1 > M2) ? M1 : M2;
    localparam int unsigned M5 = (M3 > T_GAP) ? M3 : T_GAP;
    localparam int unsigned T_MAX = (M4 > M5) ? M4 : M5;
    localparam int unsigned CW = $clog2(T_MAX + 1);

    seq_state_e    state_q, state_d;
    logic [CW-1:0] phase_limit;
    logic          phase_hit;
    logic          timer_run;
    logic          timer_clr;
    logic          poll_sample;
    logic [1:0]    link_q;
    logic [1:0]    phy_mask;
    logic          all_up;
    logic          last_poll;
    logic          unused_sts_bit0;

    assign unused_sts_bit0 = link_sts_i[0];

    // phase length selection
    always_comb begin
        unique case (state_q)
            ST_DEV_HOLD:   phase_limit = CW'(T_DEV_LOW);
            ST_CLK_ON:     phase_limit = CW'(T_CLK_ON);
            ST_CTRL_REL_A: phase_limit = CW'(T_REL_A);
            ST_CTRL_HOLD:  phase_limit = CW'(T_CTRL_HOLD);
            ST_CTRL_REL_B: phase_limit = CW'(T_REL_B);
            ST_SETTLE:     phase_limit = CW'(T_SETTLE);
            ST_POLL:       phase_limit = CW'(1);
            ST_GAP:        phase_limit = CW'(T_GAP);
            ST_FINISH:     phase_limit = CW'(1);
            default:       phase_limit = CW'(1);
        endcase
    end

    assign timer_run   = (state_q != ST_FINISH);
    assign timer_clr   = (state_d != state_q);
    assign poll_sample = (state_q == ST_POLL);

    rp_phase_timer #(
        .CW (CW)
    ) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (timer_run),
        .clr   (timer_clr),
        .limit (phase_limit),
        .hit   (phase_hit)
    );

    rp_link_poller #(
        .PORT1_EN (PORT1_EN),
        .POLL_MAX (POLL_MAX)
    ) poller_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample       (poll_sample),
        .link_raw     (link_sts_i[2:1]),
        .link_q       (link_q),
        .phy_off_mask (phy_mask),
        .all_up       (all_up),
        .last_poll    (last_poll)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DEV_HOLD:   if (phase_hit) state_d = ST_CLK_ON;
            ST_CLK_ON:     if (phase_hit) state_d = ST_CTRL_REL_A;
            ST_CTRL_REL_A: if (phase_hit) state_d = ST_CTRL_HOLD;
            ST_CTRL_HOLD:  if (phase_hit) state_d = ST_CTRL_REL_B;
            ST_CTRL_REL_B: if (phase_hit) state_d = ST_SETTLE;
            ST_SETTLE:     if (phase_hit) state_d = ST_POLL;
            ST_POLL:       state_d = (all_up || last_poll) ? ST_FINISH : ST_GAP;
            ST_GAP:        if (phase_hit) state_d = ST_POLL;
            ST_FINISH:     state_d = ST_FINISH;
            default:       state_d = ST_DEV_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DEV_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // output decode
    always_comb begin
        dev_rst_n_o    = 2'b11;
        port1_clk_en_o = 1'b1;
        ctrl_rst_o     = 3'b000;
        phy_off_o      = 2'b00;
        link_up_o      = 2'b00;
        host_en_o      = 1'b0;
        done_o         = 1'b0;
        unique case (state_q)
            ST_DEV_HOLD: begin
                dev_rst_n_o    = 2'b00;
                port1_clk_en_o = 1'b0;
                ctrl_rst_o     = 3'b111;
            end
            ST_CLK_ON: begin
                dev_rst_n_o = 2'b00;
                ctrl_rst_o  = 3'b111;
            end
            ST_CTRL_REL_A, ST_CTRL_REL_B: begin
                dev_rst_n_o = 2'b00;
            end
            ST_CTRL_HOLD: begin
                dev_rst_n_o = 2'b00;
                ctrl_rst_o  = 3'b111;
            end
            ST_SETTLE, ST_POLL, ST_GAP: begin
            end
            ST_FINISH: begin
                phy_off_o = phy_mask;
                link_up_o = link_q;
                host_en_o = (link_q != 2'b00);
                done_o    = 1'b1;
            end
            default: begin
                dev_rst_n_o = 2'b00;
                ctrl_rst_o  = 3'b111;
            end
        endcase
    end

    assert_ctrl_together_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ctrl_rst_o) == 0) || ($countones(ctrl_rst_o) == 3));

    assert_clk_before_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rst_o == 3'b000) |-> port1_clk_en_o);

    assert_dev_after_ctrl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rst_n_o != 2'b00) |-> (ctrl_rst_o == 3'b000));

    assert_sample_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        poll_sample |-> (dev_rst_n_o == 2'b11));

    assert_early_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_sample && all_up) |=> done_o);

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o);

    assert_final_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> ($stable(link_up_o) && $stable(phy_off_o) && $stable(host_en_o)));

    assert_phy_only_dead_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_off_o & link_up_o) == 2'b00);

    assert_phy_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_off_o != 2'b00) |-> done_o);

    assert_host_needs_link_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_en_o |-> (done_o && link_up_o != 2'b00));

endmodule

// File: tb/rp_bringup_seq_tb_top.sv
module rp_bringup_seq_tb_top;

    localparam int NEVER = 100000;
    localparam int LAST_E = 75;

    typedef struct packed {
        int         up0;
        int         up1;
        int         done_at;
        logic [1:0] lk;
        logic [1:0] phy;
        logic       host;
        int         p0_done;
        logic [1:0] p0_lk;
        logic [1:0] p0_phy;
        logic       p0_host;
    } vec_t;

    // first poll at edge 40, later ones every 6 edges, last at edge 64
    localparam vec_t VECS [6] = '{
        '{0,     0,     40, 2'b11, 2'b00, 1'b1, 40, 2'b01, 2'b00, 1'b1},
        '{0,     50,    52, 2'b11, 2'b00, 1'b1, 40, 2'b01, 2'b00, 1'b1},
        '{NEVER, 0,     64, 2'b10, 2'b01, 1'b1, 64, 2'b00, 2'b01, 1'b0},
        '{66,    66,    64, 2'b00, 2'b11, 1'b0, 64, 2'b00, 2'b01, 1'b0},
        '{55,    43,    58, 2'b11, 2'b00, 1'b1, 58, 2'b01, 2'b00, 1'b1},
        '{0,     61,    64, 2'b11, 2'b00, 1'b1, 40, 2'b01, 2'b00, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] link_sts = 3'b000;
    int         cyc = 0;
    int         up0 = NEVER;
    int         up1 = NEVER;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         finished = 1'b0;

    logic [1:0] a_dev, b_dev, a_phy, b_phy, a_lk, b_lk;
    logic [2:0] a_ctrl, b_ctrl;
    logic       a_clk, b_clk, a_host, b_host, a_done, b_done;

    always #5 clk = ~clk;

    always_ff @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    rp_bringup_seq #(
        .T_DEV_LOW(4), .T_CLK_ON(3), .T_REL_A(5), .T_CTRL_HOLD(9),
        .T_REL_B(6), .T_SETTLE(12), .T_GAP(5), .POLL_MAX(5), .PORT1_EN(1)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .link_sts_i(link_sts),
        .dev_rst_n_o(a_dev), .port1_clk_en_o(a_clk), .ctrl_rst_o(a_ctrl),
        .phy_off_o(a_phy), .link_up_o(a_lk), .host_en_o(a_host), .done_o(a_done)
    );

    rp_bringup_seq #(
        .T_DEV_LOW(4), .T_CLK_ON(3), .T_REL_A(5), .T_CTRL_HOLD(9),
        .T_REL_B(6), .T_SETTLE(12), .T_GAP(5), .POLL_MAX(5), .PORT1_EN(0)
    ) dut_p0_i (
        .clk(clk), .rst_n(rst_n), .link_sts_i(link_sts),
        .dev_rst_n_o(b_dev), .port1_clk_en_o(b_clk), .ctrl_rst_o(b_ctrl),
        .phy_off_o(b_phy), .link_up_o(b_lk), .host_en_o(b_host), .done_o(b_done)
    );

    // link stimulus: bit 0 is noise, bits 2:1 rise at the chosen cycles
    initial begin
        forever begin
            @(negedge clk);
            link_sts = {(cyc >= up1), (cyc >= up0), cyc[0]};
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    task automatic at_edge(input int n);
        do begin
            @(posedge clk);
            #1;
        end while (cyc != n);
        #2;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        // R1: reset state
        up0 = 0; up1 = 0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 dev_rst_n", a_dev, 0);
        chk("R1 clk_en", a_clk, 0);
        chk("R1 ctrl_rst", a_ctrl, 7);
        chk("R1 phy_off", a_phy, 0);
        chk("R1 link_up", a_lk, 0);
        chk("R1 host_en", a_host, 0);
        chk("R1 done", a_done, 0);
        rst_n = 1'b1;

        // R2/R3/R4: phase timing
        at_edge(3);
        chk("R2 clk off at 3", a_clk, 0);
        chk("R2 dev low at 3", a_dev, 0);
        at_edge(4);
        chk("R2 clk on at 4", a_clk, 1);
        chk("R2 ctrl held at 4", a_ctrl, 7);
        at_edge(6);
        chk("R2 ctrl held at 6", a_ctrl, 7);
        at_edge(7);
        chk("R3 ctrl released at 7", a_ctrl, 0);
        at_edge(11);
        chk("R3 ctrl released at 11", a_ctrl, 0);
        at_edge(12);
        chk("R3 ctrl asserted at 12", a_ctrl, 7);
        at_edge(20);
        chk("R3 ctrl asserted at 20", a_ctrl, 7);
        at_edge(21);
        chk("R3 ctrl released at 21", a_ctrl, 0);
        chk("R3 dev low at 21", a_dev, 0);
        at_edge(26);
        chk("R3 dev low at 26", a_dev, 0);
        at_edge(27);
        chk("R4 dev released at 27", a_dev, 3);
        chk("R2 clk stays on at 27", a_clk, 1);
        at_edge(39);
        chk("R4 no early sample", a_done, 0);

        // table walk: R5 R6 R7 R8 R9 R10
        foreach (VECS[i]) begin
            up0 = VECS[i].up0;
            up1 = VECS[i].up1;
            do_reset();
            for (int e = 1; e <= LAST_E; e++) begin
                at_edge(e);
                if (e == VECS[i].done_at - 1) chk("R5 two-port done early", a_done, 0);
                if (e == VECS[i].done_at) begin
                    chk("R6 two-port done", a_done, 1);
                    chk("R7 two-port link_up", a_lk, VECS[i].lk);
                    chk("R8 two-port phy_off", a_phy, VECS[i].phy);
                    chk("R9 two-port host_en", a_host, VECS[i].host);
                end
                if (e == VECS[i].p0_done - 1) chk("R9 one-port done early", b_done, 0);
                if (e == VECS[i].p0_done) begin
                    chk("R9 one-port done", b_done, 1);
                    chk("R9 one-port link_up", b_lk, VECS[i].p0_lk);
                    chk("R8 one-port phy_off", b_phy, VECS[i].p0_phy);
                    chk("R9 one-port host_en", b_host, VECS[i].p0_host);
                end
                if (e == LAST_E) begin
                    chk("R10 two-port done held", a_done, 1);
                    chk("R10 two-port link frozen", a_lk, VECS[i].lk);
                    chk("R10 two-port phy frozen", a_phy, VECS[i].phy);
                    chk("R10 two-port host frozen", a_host, VECS[i].host);
                    chk("R10 one-port link frozen", b_lk, VECS[i].p0_lk);
                end
            end
        end

        // R1: reset mid-sequence returns to the initial state
        up0 = 0; up1 = 0;
        do_reset();
        at_edge(30);
        rst_n = 1'b0;
        #3;
        chk("R1 reset mid-run dev", a_dev, 0);
        chk("R1 reset mid-run ctrl", a_ctrl, 7);
        chk("R1 reset mid-run clk", a_clk, 0);
        rst_n = 1'b1;

        summary();
    end

endmodule